// File: doc/BRIEF.md
# Octal Double-Buffered DAC Code Register Bank

This block is the digital front end of an eight-channel, 14-bit converter with parallel load. A host presents a data word and a channel address. It writes by pulling chip-select and the write strobe low. On the rising edge of the write strobe, the word is captured into the addressed channel's input register.

A separate active-low load strobe copies every input register into its DAC register at once, so all eight converter codes change together. When the load strobe is held low, writes become transparent: the addressed channel's code updates in the same step as the capture.

An active-low clear forces every output code to the zero-volt code for as long as it is held low. Clear does not change any stored register, so releasing it brings back the codes held in the DAC registers. All strobes are asynchronous to the block. They pass through a synchronizer into the single system clock domain. Address and data are delayed by the same number of stages, so they line up with the detected write edge.

Top module: `octal_dac_regbank`

## Requirements
- R1: After reset, every channel's output code is the midscale zero-volt code 0x2000 (binary 10 0000 0000 0000).
- R2: A write while the load strobe is high changes no output code.
- R3: While the load strobe is low, every DAC register takes its input register's value in the same clock, so all outputs change together.
- R4: A write updates only the channel selected by the 3-bit address (0 selects the lowest 14-bit slice of `code_out`, 7 the highest); no other channel's registers change.
- R5: A write strobe pulse while chip-select is high changes no register.
- R6: The word captured is the one present on the data bus during the last sampled low cycle of the write strobe. Bus changes after the write strobe rises are not captured.
- R7: With the load strobe held low, the addressed channel's output shows the new word after that same write edge, not one write later.
- R8: While clear is low, every output code is 0x2000.
- R9: Writes and loads made while clear is low still update the registers. After clear returns high, each output shows its DAC register value.
- R10: Codes pass unaltered with bit 13 as MSB and bit 0 as LSB, including the extremes 0x0000 (negative full scale) and 0x3FFF (positive full scale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select |
| wr_n | input | 1 | Active-low write strobe; captured on its rising edge |
| load_n | input | 1 | Active-low simultaneous load of all DAC registers |
| clear_n | input | 1 | Active-low level-sensitive output clear |
| addr | input | 3 | Channel address |
| din | input | 14 | Data word, bit 13 MSB |
| code_out | output | 112 | Eight 14-bit output codes, channel i at bits [14*i+13:14*i] |

## Verification
The bench builds the block with its default parameters: eight channels of 14 bits, a two-stage synchronizer and combinational output selection. These values bring the whole 3-bit address space within reach. They also allow each channel to be driven to both code extremes and to midscale. A data change part-way through a long write strobe shows which sample is captured. Load held low and clear overlapping writes and loads cover the transparent path and the non-destructive clear.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
   // Strobe slot positions inside the synchronized strobe vector
   localparam int STB_CS  = 0;
   localparam int STB_WR  = 1;
   localparam int STB_LD  = 2;
   localparam int STB_CLR = 3;
   localparam int STB_W   = 4;

   // Midscale code: MSB set, all other bits clear
   function automatic logic [63:0] midscale(input int unsigned w);
      logic [63:0] v;
      v = '0;
      v[w-1] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/dacbank_delay.sv
module dacbank_delay #(
   parameter int          W     = 1,
   parameter int          DEPTH = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dacbank_delay: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= INIT;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[DEPTH-1];
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
   parameter int           W    = 14,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         ld_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] in_q,
   output logic [W-1:0] dac_q
);
   logic [W-1:0] in_next;

   // New word bypasses into the DAC register when load is active
   assign in_next = wr_en ? wdata : in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= INIT;
         dac_q <= INIT;
      end else begin
         in_q <= in_next;
         if (ld_en) dac_q <= in_next;
      end
   end
endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank #(
   parameter int NUM_CH      = 8,
   parameter int CODE_W      = 14,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b0,
   localparam int ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int BUS_W      = NUM_CH * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              load_n,
   input  logic              clear_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] din,
   output logic [BUS_W-1:0]  code_out
);
   import dacbank_pkg::*;

   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(midscale(CODE_W));
   localparam int                PAY_W    = ADDR_W + CODE_W;

   generate
      if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_ch
         $error("octal_dac_regbank: NUM_CH out of range");
      end
      if (CODE_W < 2 || CODE_W > 32) begin : g_bad_w
         $error("octal_dac_regbank: CODE_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("octal_dac_regbank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Strobe synchronizer (idle level is high)
   logic [STB_W-1:0] stb_raw, stb_s;
   assign stb_raw[STB_CS]  = cs_n;
   assign stb_raw[STB_WR]  = wr_n;
   assign stb_raw[STB_LD]  = load_n;
   assign stb_raw[STB_CLR] = clear_n;

   dacbank_delay #(.W(STB_W), .DEPTH(SYNC_STAGES), .INIT('1)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s)
   );

   // One more stage of write and chip-select for edge detection
   logic [1:0] wc_q;
   dacbank_delay #(.W(2), .DEPTH(1), .INIT('1)) u_edge (
      .clk(clk), .rst_n(rst_n), .d({stb_s[STB_WR], stb_s[STB_CS]}), .q(wc_q)
   );

   logic wr_q, cs_q_n;
   assign wr_q   = wc_q[1];
   assign cs_q_n = wc_q[0];

   // Address and data delayed to match the last low write sample
   logic [PAY_W-1:0] pay_q;
   dacbank_delay #(.W(PAY_W), .DEPTH(SYNC_STAGES + 1), .INIT('0)) u_bus_dly (
      .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(pay_q)
   );

   logic [ADDR_W-1:0] waddr;
   logic [CODE_W-1:0] wdata;
   assign {waddr, wdata} = pay_q;

   logic wr_valid, ld_act, clr_act;
   assign wr_valid = stb_s[STB_WR] & ~wr_q & ~cs_q_n;
   assign ld_act   = ~stb_s[STB_LD];
   assign clr_act  = ~stb_s[STB_CLR];

   logic [NUM_CH-1:0] wr_hit;
   logic [BUS_W-1:0]  in_flat, dac_flat, out_next;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         assign wr_hit[ch] = wr_valid && (waddr == ADDR_W'(ch));

         dacbank_chan #(.W(CODE_W), .INIT(MID_CODE)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_hit[ch]),
            .ld_en (ld_act),
            .wdata (wdata),
            .in_q  (in_flat[ch*CODE_W +: CODE_W]),
            .dac_q (dac_flat[ch*CODE_W +: CODE_W])
         );

         assign out_next[ch*CODE_W +: CODE_W] =
            clr_act ? MID_CODE : dac_flat[ch*CODE_W +: CODE_W];
      end

      if (REG_OUT) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_out <= {NUM_CH{MID_CODE}};
            else        code_out <= out_next;
         end
      end else begin : g_out_comb
         assign code_out = out_next;
      end
   endgenerate
endmodule

// File: rtl/octal_dac_regbank_chk.sv
module octal_dac_regbank_chk #(
   parameter int NUM_CH  = 8,
   parameter int CODE_W  = 14,
   parameter bit REG_OUT = 1'b0,
   localparam int BUS_W  = NUM_CH * CODE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_act,
   input logic              clr_act,
   input logic              cs_q_n,
   input logic [NUM_CH-1:0] wr_hit,
   input logic [BUS_W-1:0]  in_flat,
   input logic [BUS_W-1:0]  dac_flat,
   input logic [BUS_W-1:0]  code_out
);
   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(dacbank_pkg::midscale(CODE_W));

   AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_act |=> $stable(dac_flat)); // R2

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_act && wr_hit == '0) |=> dac_flat == $past(in_flat)); // R3

   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit)); // R4

   AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q_n |=> $stable(in_flat)); // R5

   AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_act && wr_hit != '0) |=> dac_flat == in_flat); // R7

   generate
      if (!REG_OUT) begin : g_comb_out
         AST_CLEAR_MID: assert property (@(posedge clk) disable iff (!rst_n)
            clr_act |-> code_out == {NUM_CH{MID_CODE}}); // R8

         AST_RELEASE_SHOWS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_act |-> code_out == dac_flat); // R9
      end
   endgenerate
endmodule

bind octal_dac_regbank octal_dac_regbank_chk #(
   .NUM_CH(NUM_CH), .CODE_W(CODE_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_act(ld_act), .clr_act(clr_act),
   .cs_q_n(cs_q_n), .wr_hit(wr_hit), .in_flat(in_flat),
   .dac_flat(dac_flat), .code_out(code_out)
);

// File: tb/octal_dac_regbank_test.sv
module octal_dac_regbank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int CW  = 14;
   localparam logic [CW-1:0] MID = 14'h2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, load_n = 1'b1, clear_n = 1'b1;
   logic [2:0] addr = '0;
   logic [CW-1:0] din = '0;
   logic [NCH*CW-1:0] code_out;

   int n_vec = 0;
   int n_bad = 0;
   logic [CW-1:0] m_in  [NCH];
   logic [CW-1:0] m_dac [NCH];
   logic clr_model = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   octal_dac_regbank uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .load_n(load_n),
      .clear_n(clear_n), .addr(addr), .din(din), .code_out(code_out)
   );

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input int ch, input logic [CW-1:0] exp);
      logic [CW-1:0] act;
      act = code_out[ch*CW +: CW];
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      for (int ch = 0; ch < NCH; ch++)
         chk(req, ch, clr_model ? MID : m_dac[ch]);
   endtask

   // Write; model updated only when selected
   task automatic bus_write(input int ch, input logic [CW-1:0] val, input logic sel_n);
      addr = 3'(ch); din = val; cs_n = sel_n; wr_n = 1'b0;
      wait_neg(3);
      wr_n = 1'b1;
      wait_neg(1);
      cs_n = 1'b1;
      wait_neg(4);
      if (!sel_n) begin
         m_in[ch] = val;
         if (!load_n) m_dac[ch] = val;
      end
   endtask

   task automatic pulse_load();
      load_n = 1'b0;
      wait_neg(4);
      load_n = 1'b1;
      wait_neg(4);
      for (int ch = 0; ch < NCH; ch++) m_dac[ch] = m_in[ch];
   endtask

   task automatic t_reset();
      chk_all("R1");
   endtask

   task automatic t_buffered();
      bus_write(3, 14'h1234, 1'b0);
      chk_all("R2");
      pulse_load();
      chk("R4", 3, 14'h1234);
      chk_all("R3");
   endtask

   task automatic t_extremes();
      bus_write(0, 14'h0000, 1'b0);
      bus_write(7, 14'h3FFF, 1'b0);
      bus_write(5, 14'h2AAA, 1'b0);
      chk_all("R2");
      pulse_load();
      chk("R10", 0, 14'h0000);
      chk("R10", 7, 14'h3FFF);
      chk_all("R3");
      chk_all("R4");
   endtask

   task automatic t_deselect();
      bus_write(1, 14'h0155, 1'b1);
      pulse_load();
      chk("R5", 1, MID);
      chk_all("R5");
   endtask

   task automatic t_edge();
      addr = 3'd4; din = 14'h0AAA; cs_n = 1'b0; wr_n = 1'b0;
      wait_neg(3);
      din = 14'h1555;
      wait_neg(3);
      wr_n = 1'b1;
      din = 14'h3C3C;
      wait_neg(1);
      din = 14'h0F00;
      wait_neg(1);
      cs_n = 1'b1;
      wait_neg(4);
      m_in[4] = 14'h1555;
      pulse_load();
      chk("R6", 4, 14'h1555);
   endtask

   task automatic t_transparent();
      load_n = 1'b0;
      wait_neg(4);
      for (int ch = 0; ch < NCH; ch++) m_dac[ch] = m_in[ch];
      bus_write(2, 14'h0F0F, 1'b0);
      chk("R7", 2, 14'h0F0F);
      bus_write(6, 14'h3001, 1'b0);
      chk("R7", 6, 14'h3001);
      chk_all("R7");
      load_n = 1'b1;
      wait_neg(4);
   endtask

   task automatic t_clear();
      clear_n = 1'b0;
      wait_neg(4);
      clr_model = 1'b1;
      chk_all("R8");
      bus_write(6, 14'h0123, 1'b0);
      pulse_load();
      chk_all("R8");
      clear_n = 1'b1;
      wait_neg(4);
      clr_model = 1'b0;
      chk("R9", 6, 14'h0123);
      chk_all("R9");
   endtask

   initial begin
      for (int ch = 0; ch < NCH; ch++) begin
         m_in[ch] = MID;
         m_dac[ch] = MID;
      end
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(4);
      t_reset();
      t_buffered();
      t_extremes();
      t_deselect();
      t_edge();
      t_transparent();
      t_clear();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule